// File: doc/BRIEF.md
# Seven-to-one pixel serializer

This block turns a 28-bit parallel pixel word into four serial data lanes plus a clock lane. Once per pixel period it latches the whole word on one edge of the pixel clock and spreads the bits over seven serial slots on each lane. The edge can be rising or falling, and it is chosen at run time. The serial side runs on a bit clock at seven times the pixel rate, which the surrounding chip provides. The outputs are meant to feed a set of differential line drivers, one per lane, and each lane has its own output enable.

Bit-clock phasing is fixed by the integration. A pixel clock rising edge must land shortly after a bit clock rising edge. The pixel clock must then stay high for four bit periods and low for three. The block finds that rising edge by sampling the pixel clock in the bit clock domain and takes its slot phase from it. The captured word is copied into a holding register on the sixth bit-clock edge after the pixel edge is seen. It reaches the lane shift registers on the following edge, which starts slot 0.

A single active-low shutdown input clears every register at once. It also forces all lane outputs and enables low. After release, the enables come up only when a frame that carries a real captured word starts. A narrow colour mode parks lane 3.

Top module: `pix_serializer`

## Requirements
- R1: With `cap_rise` = 1 the word on `pix_data` is latched on the rising edge of `pix_clk`, and that latched word is the one serialized.
- R2: With `cap_rise` = 0 the word is latched on the falling edge of `pix_clk` instead, and that latched word is the one serialized.
- R3: Slot s of a frame (s = 0 first, one bit-clock period per slot) carries, on lanes 0,1,2,3, these input bits: s0: 1,9,20,5; s1: 0,8,19,27; s2: 7,18,26,23; s3: 6,15,25,17; s4: 4,14,24,16; s5: 3,13,22,11; s6: 2,12,21,10.
- R4: While enabled, `clk_lane` shows the levels 1,1,0,0,0,1,1 in slots 0 to 6 of every frame, so it repeats every 7 bit clocks at the pixel frequency.
- R5: Every word latched after the first emitted frame is emitted exactly once, in latch order. Frames follow each other with no idle slot.
- R6: While `halt_n` is low, all of `lane_dat`, `clk_lane`, `lane_oe` and `clk_oe` are 0. This takes effect at once, with no clock edge needed, and all internal state is cleared.
- R7: After `halt_n` rises, all enables stay 0 until the first frame that holds a latched word. They then rise together in slot 0, when `clk_lane` is 1, and stay high. That first frame carries one of the first two words latched after release.
- R8: With `narrow18` = 1 (changed only while halted), `lane_oe[3]` and `lane_dat[3]` stay 0 and lanes 0 to 2 keep their R3 contents. Input bits 5, 10, 11, 16, 17, 23 and 27 are therefore not transmitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock, one word per period |
| bit_clk | input | 1 | Serial clock at seven times the pixel rate, phase-related to `pix_clk` |
| halt_n | input | 1 | Active-low shutdown and clear |
| cap_rise | input | 1 | 1 latches on the rising pixel edge, 0 on the falling edge |
| narrow18 | input | 1 | 1 parks lane 3 (reduced colour depth) |
| pix_data | input | 28 | Parallel pixel word |
| lane_dat | output | 4 | Serial data lanes 0 to 3 |
| clk_lane | output | 1 | Serial clock-lane pattern |
| lane_oe | output | 4 | Output enable per data lane |
| clk_oe | output | 1 | Output enable of the clock lane |

## Verification
Each pixel period has one latch of the next pixel word and one transfer of the current word toward the shift registers. If the block got their order wrong, a word would be overwritten before it left, or sent twice. The stimulus changes `pix_data` twice per pixel period, once between the two pixel edges and once before the next rising edge, so the unused edge always sees a decoy value. Both edge settings run back to back with random and walking-one words. The serial streams are rebuilt from the clock-lane pattern with the inverse slot table, and each rebuilt word must equal the next latched word in order.

// File: rtl/pxs_pkg.sv
`timescale 1ns/1ps
package pxs_pkg;

  localparam int unsigned LANES       = 4;
  localparam int unsigned SLOTS       = 7;
  localparam int unsigned WORD_W      = LANES * SLOTS;
  localparam int unsigned PH_W        = $clog2(SLOTS);
  localparam int unsigned NARROW_LANE = LANES - 1;

  // clock-lane levels, slot 0 in the MSB
  localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;

  typedef logic [WORD_W-1:0] pix_word_t;

  // input bit carried by a given slot and lane
  function automatic int unsigned src_bit(input int unsigned slot, input int unsigned lane);
    int unsigned idx;
    idx = slot * LANES + lane;
    case (idx)
      0:  return 1;   1:  return 9;   2:  return 20;  3:  return 5;
      4:  return 0;   5:  return 8;   6:  return 19;  7:  return 27;
      8:  return 7;   9:  return 18;  10: return 26;  11: return 23;
      12: return 6;   13: return 15;  14: return 25;  15: return 17;
      16: return 4;   17: return 14;  18: return 24;  19: return 16;
      20: return 3;   21: return 13;  22: return 22;  23: return 11;
      24: return 2;   25: return 12;  26: return 21;  27: return 10;
      default: return 0;
    endcase
  endfunction

  // all input bits that travel on one lane
  function automatic pix_word_t lane_mask(input int unsigned lane);
    pix_word_t m;
    m = '0;
    for (int unsigned s = 0; s < SLOTS; s++) begin
      m[src_bit(s, lane)] = 1'b1;
    end
    return m;
  endfunction

  localparam pix_word_t NARROW_MASK = lane_mask(NARROW_LANE);

endpackage

// File: rtl/pxs_capture.sv
`timescale 1ns/1ps
module pxs_capture
  import pxs_pkg::*;
(
  input  logic      pix_clk,
  input  logic      halt_n,
  input  logic      cap_rise,
  input  pix_word_t pix_data,
  output pix_word_t cap_word,
  output logic      cap_vld
);

  pix_word_t rise_q, rise_d;
  pix_word_t fall_q, fall_d;
  logic      rvld_q, rvld_d;
  logic      fvld_q, fvld_d;

  // clock enables: only the selected edge register loads
  always_comb begin
    rise_d = rise_q;
    rvld_d = rvld_q;
    if (cap_rise) begin
      rise_d = pix_data;
      rvld_d = 1'b1;
    end
  end

  always_comb begin
    fall_d = fall_q;
    fvld_d = fvld_q;
    if (!cap_rise) begin
      fall_d = pix_data;
      fvld_d = 1'b1;
    end
  end

  always_ff @(posedge pix_clk or negedge halt_n) begin
    if (!halt_n) begin
      rise_q <= '0;
      rvld_q <= 1'b0;
    end else begin
      rise_q <= rise_d;
      rvld_q <= rvld_d;
    end
  end

  always_ff @(negedge pix_clk or negedge halt_n) begin
    if (!halt_n) begin
      fall_q <= '0;
      fvld_q <= 1'b0;
    end else begin
      fall_q <= fall_d;
      fvld_q <= fvld_d;
    end
  end

  assign cap_word = cap_rise ? rise_q : fall_q;
  assign cap_vld  = cap_rise ? rvld_q : fvld_q;

endmodule

// File: rtl/pxs_frame_ctl.sv
`timescale 1ns/1ps
module pxs_frame_ctl
  import pxs_pkg::*;
(
  input  logic             bit_clk,
  input  logic             halt_n,
  input  logic             pix_clk,
  input  logic             narrow18,
  input  pix_word_t        cap_word,
  input  logic             cap_vld,
  output logic             rst_b_n,
  output pix_word_t        hold_word,
  output logic             shift_ld,
  output logic [LANES-1:0] lane_oe,
  output logic             clk_oe
);

  localparam logic [PH_W-1:0] RISE_PH = PH_W'(2);
  localparam logic [PH_W-1:0] HOLD_PH = PH_W'(SLOTS - 2);
  localparam logic [PH_W-1:0] LOAD_PH = PH_W'(SLOTS - 1);

  logic [1:0]       rsync_q;
  logic             pix_s_q, pix_d_q;
  logic             rise_seen;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             locked_q, locked_d;
  logic             hold_ld;
  pix_word_t        hold_q, hold_d;
  logic             hvld_q, hvld_d;
  logic [LANES-1:0] loe_q, loe_d;
  logic             coe_q, coe_d;

  // reset: asserted at once, released on the bit clock
  always_ff @(posedge bit_clk or negedge halt_n) begin
    if (!halt_n) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_b_n = rsync_q[1];

  // pixel-edge detection; reset high so only a seen low-to-high counts
  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n) begin
      pix_s_q <= 1'b1;
      pix_d_q <= 1'b1;
    end else begin
      pix_s_q <= pix_clk;
      pix_d_q <= pix_s_q;
    end
  end
  assign rise_seen = pix_s_q & ~pix_d_q;

  assign hold_ld  = locked_q && (ph_q == HOLD_PH);
  assign shift_ld = locked_q && (ph_q == LOAD_PH);

  always_comb begin
    if (rise_seen)               ph_d = RISE_PH;
    else if (ph_q == LOAD_PH)    ph_d = '0;
    else                         ph_d = ph_q + PH_W'(1);
    locked_d = locked_q | rise_seen;
  end

  always_comb begin
    hold_d = hold_q;
    hvld_d = hvld_q;
    if (hold_ld) begin
      hold_d = narrow18 ? (cap_word & ~NARROW_MASK) : cap_word;
      hvld_d = hvld_q | cap_vld;
    end
  end

  always_comb begin
    coe_d = coe_q;
    loe_d = loe_q;
    if (shift_ld) begin
      coe_d = hvld_q;
      for (int unsigned l = 0; l < LANES; l++) begin
        loe_d[l] = hvld_q && !(narrow18 && (l == NARROW_LANE));
      end
    end
  end

  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n) begin
      ph_q     <= '0;
      locked_q <= 1'b0;
      hold_q   <= '0;
      hvld_q   <= 1'b0;
      loe_q    <= '0;
      coe_q    <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      locked_q <= locked_d;
      hold_q   <= hold_d;
      hvld_q   <= hvld_d;
      loe_q    <= loe_d;
      coe_q    <= coe_d;
    end
  end

  assign hold_word = hold_q;
  assign lane_oe   = loe_q;
  assign clk_oe    = coe_q;

endmodule

// File: rtl/pxs_piso.sv
`timescale 1ns/1ps
module pxs_piso #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par,
  output logic         ser
);

  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    if (load) sr_d = par;
    else      sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign ser = sr_q[W-1];

endmodule

// File: rtl/pix_serializer.sv
`timescale 1ns/1ps
module pix_serializer
  import pxs_pkg::*;
(
  input  logic              pix_clk,
  input  logic              bit_clk,
  input  logic              halt_n,
  input  logic              cap_rise,
  input  logic              narrow18,
  input  logic [WORD_W-1:0] pix_data,
  output logic [LANES-1:0]  lane_dat,
  output logic              clk_lane,
  output logic [LANES-1:0]  lane_oe,
  output logic              clk_oe
);

  pix_word_t cap_word;
  logic      cap_vld;
  logic      rst_b_n;
  pix_word_t hold_word;
  logic      shift_ld;

  pxs_capture u_cap (
    .pix_clk  (pix_clk),
    .halt_n   (halt_n),
    .cap_rise (cap_rise),
    .pix_data (pix_data),
    .cap_word (cap_word),
    .cap_vld  (cap_vld)
  );

  pxs_frame_ctl u_ctl (
    .bit_clk   (bit_clk),
    .halt_n    (halt_n),
    .pix_clk   (pix_clk),
    .narrow18  (narrow18),
    .cap_word  (cap_word),
    .cap_vld   (cap_vld),
    .rst_b_n   (rst_b_n),
    .hold_word (hold_word),
    .shift_ld  (shift_ld),
    .lane_oe   (lane_oe),
    .clk_oe    (clk_oe)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] par;
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int unsigned SRC = src_bit(s, l);
      assign par[SLOTS-1-s] = hold_word[SRC];
    end
    pxs_piso #(.W(SLOTS)) u_ser (
      .clk   (bit_clk),
      .rst_n (rst_b_n),
      .load  (shift_ld),
      .par   (par),
      .ser   (lane_dat[l])
    );
  end

  pxs_piso #(.W(SLOTS)) u_clk_ser (
    .clk   (bit_clk),
    .rst_n (rst_b_n),
    .load  (shift_ld),
    .par   (CLK_PAT),
    .ser   (clk_lane)
  );

endmodule

// File: rtl/pxs_chk.sv
`timescale 1ns/1ps
module pxs_chk
  import pxs_pkg::*;
(
  input logic             bit_clk,
  input logic             halt_n,
  input logic             narrow18,
  input logic [LANES-1:0] lane_dat,
  input logic             clk_lane,
  input logic [LANES-1:0] lane_oe,
  input logic             clk_oe
);

  logic [2:0] mode_age_q;
  logic       mode_q;

  always_ff @(posedge bit_clk or negedge halt_n) begin
    if (!halt_n) begin
      mode_age_q <= '0;
      mode_q     <= 1'b0;
    end else begin
      mode_q <= narrow18;
      if (narrow18 != mode_q)  mode_age_q <= '0;
      else if (mode_age_q != 3'd7) mode_age_q <= mode_age_q + 3'd1;
    end
  end

  // R6
  always @(posedge bit_clk) begin
    if (!halt_n) begin
      halt_quiet_chk: assert (lane_oe == '0 && !clk_oe && lane_dat == '0 && !clk_lane);
    end
  end

  // R4
  clk_low_run_chk: assert property (@(posedge bit_clk) disable iff (!halt_n)
    (clk_oe && $fell(clk_lane)) |=> (!clk_lane ##1 !clk_lane ##1 clk_lane));

  // R4
  clk_high_run_chk: assert property (@(posedge bit_clk) disable iff (!halt_n)
    (clk_oe && $past(clk_oe) && $rose(clk_lane)) |=> (clk_lane ##1 clk_lane ##1 clk_lane ##1 !clk_lane));

  // R7
  oe_start_chk: assert property (@(posedge bit_clk) disable iff (!halt_n)
    $rose(clk_oe) |-> (clk_lane && lane_oe[2:0] == 3'b111));

  // R7
  oe_sticky_chk: assert property (@(posedge bit_clk) disable iff (!halt_n)
    clk_oe |=> clk_oe);

  // R7
  lanes_off_chk: assert property (@(posedge bit_clk) disable iff (!halt_n)
    !clk_oe |-> (lane_oe == '0));

  // R8
  narrow_park_chk: assert property (@(posedge bit_clk) disable iff (!halt_n)
    (narrow18 && mode_age_q == 3'd7) |-> (!lane_oe[3] && !lane_dat[3]));

endmodule

bind pix_serializer pxs_chk chk_i (
  .bit_clk  (bit_clk),
  .halt_n   (halt_n),
  .narrow18 (narrow18),
  .lane_dat (lane_dat),
  .clk_lane (clk_lane),
  .lane_oe  (lane_oe),
  .clk_oe   (clk_oe)
);

// File: tb/pix_serializer_tb_top.sv
`timescale 1ns/1ps
module pix_serializer_tb_top;

  logic        bit_clk  = 1'b0;
  logic        pix_clk  = 1'b0;
  logic        halt_n   = 1'b0;
  logic        cap_rise = 1'b1;
  logic        narrow18 = 1'b0;
  logic [27:0] pix_data = '0;
  logic [3:0]  lane_dat;
  logic        clk_lane;
  logic [3:0]  lane_oe;
  logic        clk_oe;

  pix_serializer dut_i (
    .pix_clk  (pix_clk),
    .bit_clk  (bit_clk),
    .halt_n   (halt_n),
    .cap_rise (cap_rise),
    .narrow18 (narrow18),
    .pix_data (pix_data),
    .lane_dat (lane_dat),
    .clk_lane (clk_lane),
    .lane_oe  (lane_oe),
    .clk_oe   (clk_oe)
  );

  // 200 MHz bit clock; pixel clock 4 bit periods high, 3 low, rising 1 ns after a bit edge
  always #2.5 bit_clk = ~bit_clk;
  initial begin
    #3.5;
    forever begin
      pix_clk = 1'b1; #20;
      pix_clk = 1'b0; #15;
    end
  end

  // slot/lane source table from R3
  int unsigned tbl [7][4] = '{'{1,9,20,5}, '{0,8,19,27}, '{7,18,26,23}, '{6,15,25,17},
                              '{4,14,24,16}, '{3,13,22,11}, '{2,12,21,10}};
  localparam logic [27:0] NARROW_BITS = (28'd1 << 5) | (28'd1 << 10) | (28'd1 << 11) |
                                        (28'd1 << 16) | (28'd1 << 17) | (28'd1 << 23) | (28'd1 << 27);

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 0;
  string       tag_now = "R5";

  logic [27:0] exp_q [0:1023];
  int unsigned wq = 0;

  function automatic logic [27:0] expect_of(input logic [27:0] w, input logic nar);
    return nar ? (w & ~NARROW_BITS) : w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of the latch: record the word on the selected edge (R1, R2)
  always @(pix_clk) begin
    if (halt_n === 1'b1 && pix_clk == cap_rise) begin
      exp_q[wq[9:0]] = pix_data;
      wq++;
    end
  end

  // deserializer and frame checker, sampling between bit-clock rising edges
  logic [6:0]  ck_hist;
  logic [6:0]  ln_hist [4];
  int unsigned oe_run, since, seg_base, rd, seg_frames;
  bit          synced, prev_oe;

  always @(negedge bit_clk) begin
    logic [27:0] got;
    int          found;
    if (halt_n !== 1'b1) begin
      synced = 0; prev_oe = 0; ck_hist = '0; oe_run = 0; since = 0;
      seg_base = wq; seg_frames = 0;
      for (int l = 0; l < 4; l++) ln_hist[l] = '0;
    end else begin
      ck_hist = {ck_hist[5:0], clk_lane};
      for (int l = 0; l < 4; l++) ln_hist[l] = {ln_hist[l][5:0], lane_dat[l]};
      oe_run = clk_oe ? ((oe_run < 7) ? oe_run + 1 : 7) : 0;
      since++;
      if (clk_oe && !prev_oe)
        check(clk_lane && lane_oe[2:0] == 3'b111, "R7 enables rise in slot 0",
              {22'd0, clk_lane, lane_oe, clk_oe}, {22'd0, 1'b1, 4'b0111, 1'b1});
      if (!clk_oe)
        check(lane_oe == 4'b0000, "R7 lane enables wait for clock lane", {24'd0, lane_oe}, 28'd0);
      prev_oe = clk_oe;
      if (oe_run == 7 && ck_hist == 7'b1100011) begin
        got = '0;
        for (int s = 0; s < 7; s++)
          for (int l = 0; l < 4; l++)
            got[tbl[s][l]] = ln_hist[l][6-s];
        check(lane_oe == (narrow18 ? 4'b0111 : 4'b1111), "R8 lane enables",
              {24'd0, lane_oe}, {24'd0, narrow18 ? 4'b0111 : 4'b1111});
        if (!synced) begin
          found = -1;
          for (int j = int'(seg_base); j < int'(wq); j++)
            if (found < 0 && expect_of(exp_q[j[9:0]], narrow18) == got) found = j;
          check(found >= 0 && found <= int'(seg_base) + 1, "R7 first frame is an early latched word",
                got, expect_of(exp_q[seg_base[9:0]], narrow18));
          rd = (found >= 0) ? found + 1 : seg_base + 1;
          synced = 1;
        end else begin
          check(since == 7, "R4 frame period 7 bit clocks", 28'(since), 28'd7);
          check(rd < wq && got == expect_of(exp_q[rd[9:0]], narrow18), tag_now,
                got, expect_of(exp_q[rd[9:0]], narrow18));
          rd++;
        end
        seg_frames++;
        since = 0;
      end
    end
  end

  task automatic run_pixels(input int n, input bit walk);
    logic [27:0] a, b;
    for (int i = 0; i < n; i++) begin
      a = 28'($urandom);
      b = 28'($urandom);
      if (walk) begin
        if (cap_rise) b = 28'd1 << (i % 28);
        else          a = 28'd1 << (i % 28);
      end
      @(posedge pix_clk);
      #10 pix_data = a;   // latched by a falling-edge setting
      #17 pix_data = b;   // latched by a rising-edge setting
    end
  endtask

  task automatic halt_now();
    @(posedge pix_clk);
    #5 halt_n = 1'b0;
    #1 check({lane_dat, clk_lane, lane_oe, clk_oe} == 10'd0, "R6 outputs clear at once",
             {18'd0, lane_dat, clk_lane, lane_oe, clk_oe}, 28'd0);
    repeat (10) @(negedge bit_clk);
    check({lane_dat, clk_lane, lane_oe, clk_oe} == 10'd0, "R6 outputs stay clear",
          {18'd0, lane_dat, clk_lane, lane_oe, clk_oe}, 28'd0);
  endtask

  task automatic release_now();
    @(posedge pix_clk);
    #5 halt_n = 1'b1;
    // before the first frame can start, enables must still be low
    repeat (3) @(negedge bit_clk);
    check(clk_oe == 1'b0 && lane_oe == 4'b0000, "R7 enables low right after release",
          {23'd0, lane_oe, clk_oe}, 28'd0);
  endtask

  task automatic segment(input bit rise, input bit nar, input int n_walk, input int n_rand, input string tag);
    int unsigned pushed;
    halt_now();
    cap_rise = rise;
    narrow18 = nar;
    release_now();
    tag_now = {tag, " walking one"};
    run_pixels(n_walk, 1'b1);
    tag_now = tag;
    run_pixels(n_rand, 1'b0);
    run_pixels(4, 1'b0);
    pushed = wq - seg_base;
    check(seg_frames + 5 >= pushed, "R5 no frames dropped",
          28'(seg_frames), 28'(pushed));
  endtask

  initial begin
    void'($urandom(32'd7321));
    #1;
    check({lane_dat, clk_lane, lane_oe, clk_oe} == 10'd0, "R6 reset state",
          {18'd0, lane_dat, clk_lane, lane_oe, clk_oe}, 28'd0);
    segment(1'b1, 1'b0, 28, 40, "R1 R3 R5 rising edge");
    segment(1'b0, 1'b0, 28, 40, "R2 R3 R5 falling edge");
    segment(1'b1, 1'b1, 0, 30, "R8 R1 narrow rising");
    segment(1'b0, 1'b1, 0, 30, "R8 R2 narrow falling");
    segment(1'b1, 1'b0, 0, 20, "R5 rising after narrow");
    halt_now();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule